// File: doc/BRIEF.md
# NAND Command Sequencer

This block drives a raw 8-bit NAND flash bus. It runs three complete operations from a single start strobe: a device reset, an identification read, and a full page read. The host gives an operation code, a 24-bit page (row) address and a chip number from 0 to 3, then pulses `start`. The block selects that chip, writes the command and address bytes, waits for the flash to report ready, and streams the bytes it reads back on `rd_data`/`rd_valid`. When it finishes it deselects the chip and pulses `done`.

Every address phase of a page read has five cycles: two column bytes that are always zero, then three row bytes taken from the page number, low byte first. Each wait for ready is bounded. If the flash stays busy for the full poll budget, the block raises `timeout` and finishes the operation anyway.

After each command or address byte the block waits a fixed number of clocks before it samples ready, so a busy indication that arrives late is not missed. The widths of the write and read strobes are parameters.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, `ce` is 0, `we_n` and `re_n` are 1, `cle`, `ale`, `dq_oe`, `done`, `timeout` and `rd_valid` are 0.
- R2: While an operation runs, `ce` is either all zero or has only bit n set, where n is the requested `chip`. It is all zero when idle.
- R3: The encoding of `op` is 0 = reset, 1 = read ID, 2 = page read. A start with `op` = 3 is ignored: there is no bus write, no chip select and no `done`.
- R4: A reset writes the command byte 0xFF, waits SETTLE clocks, then waits for ready. It reads no data.
- R5: A read ID writes command 0x90 and one address byte 0x00, then reads exactly ID_BYTES (5) bytes.
- R6: A page read writes command 0x00, then address bytes 0x00, 0x00, page[7:0], page[15:8] and page[23:16], then command 0x30. It then waits for ready and reads PAGE_BYTES bytes.
- R7: `cle` is high only during a command byte write and `ale` only during an address byte write, never both at once. `we_n` is low for exactly WE_W clocks per byte.
- R8: Each read holds `re_n` low for RE_W clocks and samples `dq_in` on the last low clock. The byte appears on `rd_data` with a one-cycle `rd_valid`, in bus order.
- R9: If `rdy` stays low for POLL_LIMIT×POLL_INT clocks of polling, `timeout` rises and the operation continues to completion.
- R10: `timeout` holds until the next accepted start, which clears it.
- R11: `done` is a one-clock pulse, and `ce` is already all zero in that same clock.
- R12: A `start` that arrives while an operation is running is ignored.
- R13: `rdy` is not sampled within GAP clocks after a write strobe ends, so a busy flag that drops a few clocks late is still waited for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when idle |
| op | input | 2 | 0 reset, 1 read ID, 2 page read, 3 none |
| page | input | 24 | Row address for a page read |
| chip | input | 2 | Chip number 0 to 3 |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | One-cycle qualifier for `rd_data` |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout | output | 1 | Ready wait expired during the last operation |
| ce | output | 4 | One-hot chip select, active high |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Byte driven onto the flash bus |
| dq_oe | output | 1 | Output enable for `dq_out` |
| dq_in | input | 8 | Byte from the flash bus |
| rdy | input | 1 | Flash ready (high) / busy (low) |

## Verification
The bench builds the block with PAGE_BYTES=12, POLL_LIMIT=4, POLL_INT=3, GAP=3, SETTLE=5 and two-clock strobes. A short page keeps the end of the data stream and the deselect that follows within a few dozen clocks. A 12-clock poll budget lets a flash model that stays busy force a timeout, while finite busy times below that budget must not cause one. The flash model drops ready four clocks after the command write. With GAP=3 that delay falls inside the gap, so a design that polled too early would begin reading while the flash is still busy.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int WE_W       = 2,
  parameter int RE_W       = 2,
  parameter int GAP        = 4,
  parameter int SETTLE     = 16,
  parameter int POLL_LIMIT = 8192,
  parameter int POLL_INT   = 64,
  parameter int ID_BYTES   = 5,
  parameter int PAGE_BYTES = 4314
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [23:0] page,
  input  logic [1:0]  chip,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        done,
  output logic        timeout,
  output logic [3:0]  ce,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  dq_out,
  output logic        dq_oe,
  input  logic [7:0]  dq_in,
  input  logic        rdy
);

  localparam int CW = $clog2(WE_W + RE_W + GAP + SETTLE + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int IW = $clog2(POLL_INT + 1);
  localparam int BW = $clog2(PAGE_BYTES + ID_BYTES + 1);

  localparam logic [1:0] OP_RST  = 2'd0;
  localparam logic [1:0] OP_ID   = 2'd1;
  localparam logic [1:0] OP_PAGE = 2'd2;

  localparam logic [2:0] K_CMD    = 3'd0;
  localparam logic [2:0] K_ADDR   = 3'd1;
  localparam logic [2:0] K_SETTLE = 3'd2;
  localparam logic [2:0] K_WAIT   = 3'd3;
  localparam logic [2:0] K_READ   = 3'd4;
  localparam logic [2:0] K_END    = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_NEXT, S_WLO, S_WHI, S_GAP, S_SETTLE, S_POLL, S_RLO, S_RHI
  } st_t;

  st_t            st;
  logic [3:0]     step;
  logic [1:0]     op_q;
  logic [23:0]    page_q;
  logic [CW-1:0]  cnt;
  logic [PW-1:0]  pcnt;
  logic [IW-1:0]  icnt;
  logic [BW-1:0]  bcnt;
  logic [7:0]     wbyte;
  logic           wcmd;
  logic [3:0]     ce_r;

  logic [2:0]     kind;
  logic [7:0]     kbyte;
  logic [BW-1:0]  nlast;

  always_comb begin
    kind  = K_END;
    kbyte = 8'h00;
    nlast = (op_q == OP_ID) ? BW'(ID_BYTES - 1) : BW'(PAGE_BYTES - 1);
    case (op_q)
      OP_RST: begin
        case (step)
          4'd0: begin kind = K_CMD; kbyte = 8'hFF; end
          4'd1: kind = K_SETTLE;
          4'd2: kind = K_WAIT;
          default: kind = K_END;
        endcase
      end
      OP_ID: begin
        case (step)
          4'd0: begin kind = K_CMD; kbyte = 8'h90; end
          4'd1: begin kind = K_ADDR; kbyte = 8'h00; end
          4'd2: kind = K_READ;
          default: kind = K_END;
        endcase
      end
      OP_PAGE: begin
        case (step)
          4'd0: begin kind = K_CMD;  kbyte = 8'h00; end
          4'd1: begin kind = K_ADDR; kbyte = 8'h00; end
          4'd2: begin kind = K_ADDR; kbyte = 8'h00; end
          4'd3: begin kind = K_ADDR; kbyte = page_q[7:0]; end
          4'd4: begin kind = K_ADDR; kbyte = page_q[15:8]; end
          4'd5: begin kind = K_ADDR; kbyte = page_q[23:16]; end
          4'd6: begin kind = K_CMD;  kbyte = 8'h30; end
          4'd7: kind = K_WAIT;
          4'd8: kind = K_READ;
          default: kind = K_END;
        endcase
      end
      default: kind = K_END;
    endcase
  end

  assign we_n   = (st != S_WLO);
  assign re_n   = (st != S_RLO);
  assign dq_oe  = (st == S_WLO) || (st == S_WHI);
  assign cle    = dq_oe && wcmd;
  assign ale    = dq_oe && !wcmd;
  assign dq_out = wbyte;
  assign ce     = ce_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      step     <= '0;
      op_q     <= '0;
      page_q   <= '0;
      cnt      <= '0;
      pcnt     <= '0;
      icnt     <= '0;
      bcnt     <= '0;
      wbyte    <= '0;
      wcmd     <= 1'b0;
      ce_r     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && op != 2'd3) begin
            op_q    <= op;
            page_q  <= page;
            ce_r    <= 4'b0001 << chip;
            step    <= '0;
            timeout <= 1'b0;
            st      <= S_NEXT;
          end
        end
        S_NEXT: begin
          cnt <= '0;
          case (kind)
            K_CMD, K_ADDR: begin
              wbyte <= kbyte;
              wcmd  <= (kind == K_CMD);
              st    <= S_WLO;
            end
            K_SETTLE: st <= S_SETTLE;
            K_WAIT: begin
              pcnt <= '0;
              icnt <= '0;
              st   <= S_POLL;
            end
            K_READ: begin
              bcnt <= '0;
              st   <= S_RLO;
            end
            default: begin
              ce_r <= '0;
              done <= 1'b1;
              st   <= S_IDLE;
            end
          endcase
        end
        S_WLO: begin
          if (cnt == CW'(WE_W - 1)) begin
            cnt <= '0;
            st  <= S_WHI;
          end else cnt <= cnt + 1'b1;
        end
        S_WHI: begin
          if (cnt == CW'(WE_W - 1)) begin
            cnt <= '0;
            st  <= S_GAP;
          end else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          if (cnt == CW'(GAP - 1)) begin
            step <= step + 4'd1;
            st   <= S_NEXT;
          end else cnt <= cnt + 1'b1;
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE - 1)) begin
            step <= step + 4'd1;
            st   <= S_NEXT;
          end else cnt <= cnt + 1'b1;
        end
        S_POLL: begin
          if (rdy) begin
            step <= step + 4'd1;
            st   <= S_NEXT;
          end else if (icnt == IW'(POLL_INT - 1)) begin
            icnt <= '0;
            if (pcnt == PW'(POLL_LIMIT - 1)) begin
              timeout <= 1'b1;
              step    <= step + 4'd1;
              st      <= S_NEXT;
            end else pcnt <= pcnt + 1'b1;
          end else icnt <= icnt + 1'b1;
        end
        S_RLO: begin
          if (cnt == CW'(RE_W - 1)) begin
            rd_data  <= dq_in;
            rd_valid <= 1'b1;
            cnt      <= '0;
            st       <= S_RHI;
          end else cnt <= cnt + 1'b1;
        end
        S_RHI: begin
          if (cnt == CW'(RE_W - 1)) begin
            cnt <= '0;
            if (bcnt == nlast) begin
              step <= step + 4'd1;
              st   <= S_NEXT;
            end else begin
              bcnt <= bcnt + 1'b1;
              st   <= S_RLO;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ce));

  a_r7_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r7_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (ce != 4'b0000));

  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!re_n));

  a_r11_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce == 4'b0000));

  a_r8_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

endmodule

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;

  localparam int WE_W = 2, RE_W = 2, GAP = 3, SETTLE = 5;
  localparam int POLL_LIMIT = 4, POLL_INT = 3, ID_BYTES = 5, PAGE_BYTES = 12;
  localparam int BUSY_DLY = 4;

  // {op, chip, page, busy}; busy 255 = stuck until the next command
  localparam logic [35:0] VEC [0:6] = '{
    {2'd0, 2'd0, 24'h000000, 8'd6},
    {2'd1, 2'd1, 24'h000000, 8'd0},
    {2'd2, 2'd2, 24'h123456, 8'd12},
    {2'd2, 2'd3, 24'hABCDEF, 8'd255},
    {2'd1, 2'd0, 24'h000000, 8'd0},
    {2'd0, 2'd3, 24'h000000, 8'd255},
    {2'd2, 2'd1, 24'h0000FF, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'd0, chip = 2'd0;
  logic [23:0] page = '0;
  logic [7:0] rd_data, dq_out, dq_in;
  logic rd_valid, done, timeout, cle, ale, we_n, re_n, dq_oe, rdy;
  logic [3:0] ce;

  nand_cmd_seq #(.WE_W(WE_W), .RE_W(RE_W), .GAP(GAP), .SETTLE(SETTLE),
    .POLL_LIMIT(POLL_LIMIT), .POLL_INT(POLL_INT), .ID_BYTES(ID_BYTES),
    .PAGE_BYTES(PAGE_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .page(page), .chip(chip),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .timeout(timeout),
    .ce(ce), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rdy(rdy));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int model_busy = 0;
  logic [23:0] page_cur = '0;
  logic [3:0] exp_ce = '0;

  logic [1:0] wk [0:511];
  logic [7:0] wb [0:511];
  logic [7:0] rv [0:511];
  int wn = 0, rn = 0, rbusy = 0, bad_we = 0, bad_re = 0, bad_ce = 0, bad_done = 0;
  int ce_on = 0, done_seen = 0;
  int welow = 0, relow = 0, rcount = 0, dly = 0, low_cnt = 0;
  logic id_mode = 1'b0, prev_we = 1'b1, prev_re = 1'b1, prev_done = 1'b0;

  function automatic logic [7:0] id_byte(int k);
    return 8'hC3 ^ 8'(k * 37);
  endfunction

  function automatic logic [7:0] page_byte(int k, logic [23:0] p);
    return 8'(k * 13) + p[7:0] + p[15:8];
  endfunction

  assign rdy   = (low_cnt == 0);
  assign dq_in = id_mode ? id_byte(rcount) : page_byte(rcount, page_cur);

  always @(negedge clk) begin
    if (!we_n) welow++;
    else begin
      if (!prev_we) begin
        if (welow != WE_W) bad_we++;
        wk[wn] = {cle, ale};
        wb[wn] = dq_out;
        wn++;
        if (cle) begin
          rcount  = 0;
          id_mode = (dq_out == 8'h90);
          low_cnt = 0;
          dly     = 0;
          if (dq_out == 8'hFF || dq_out == 8'h30) dly = BUSY_DLY;
        end
      end
      welow = 0;
    end
    if (dly > 0) begin
      dly--;
      if (dly == 0) low_cnt = model_busy;
    end else if (low_cnt > 0 && low_cnt < 255) low_cnt--;
    if (!re_n && prev_re && !rdy) rbusy++;
    if (!re_n) relow++;
    else begin
      if (!prev_re) begin
        if (relow != RE_W) bad_re++;
        rcount++;
      end
      relow = 0;
    end
    if (rd_valid) begin rv[rn] = rd_data; rn++; end
    if (ce != 4'b0000) ce_on++;
    if (ce != 4'b0000 && ce != exp_ce) bad_ce++;
    if (done) done_seen++;
    if (done && prev_done) bad_done++;
    prev_we = we_n;
    prev_re = re_n;
    prev_done = done;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [1:0] c,
                        input logic [23:0] p, input int busy, input int inject_at);
    logic [1:0] ek [0:7];
    logic [7:0] eb [0:7];
    int en, er, w0, r0, b0, got;
    bit ok, tmo;
    string tag;
    tag = (o == 2'd0) ? "R4" : (o == 2'd1) ? "R5" : "R6";
    en = 0;
    if (o == 2'd0) begin ek[0] = 2'b10; eb[0] = 8'hFF; en = 1; er = 0; end
    else if (o == 2'd1) begin
      ek[0] = 2'b10; eb[0] = 8'h90; ek[1] = 2'b01; eb[1] = 8'h00; en = 2; er = ID_BYTES;
    end else begin
      ek[0] = 2'b10; eb[0] = 8'h00;
      ek[1] = 2'b01; eb[1] = 8'h00;
      ek[2] = 2'b01; eb[2] = 8'h00;
      ek[3] = 2'b01; eb[3] = p[7:0];
      ek[4] = 2'b01; eb[4] = p[15:8];
      ek[5] = 2'b01; eb[5] = p[23:16];
      ek[6] = 2'b10; eb[6] = 8'h30;
      en = 7; er = PAGE_BYTES;
    end
    @(negedge clk);
    model_busy = busy; page_cur = p; exp_ce = 4'b0001 << c;
    w0 = wn; r0 = rn; b0 = rbusy;
    op = o; chip = c; page = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(timeout == 1'b0, "R10", "timeout cleared by start", timeout, 0);
    got = 0; tmo = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (i == inject_at) begin op = 2'd1; chip = c + 2'd1; start = 1'b1; end
      else start = 1'b0;
      if (done) begin got = 1; tmo = timeout; break; end
      @(negedge clk);
    end
    start = 1'b0;
    chk(got == 1, tag, "done seen", got, 1);
    chk(ce == 4'b0000, "R11", "ce cleared with done", ce, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done is a single pulse", done, 0);
    chk(timeout == tmo, "R10", "timeout held after done", timeout, tmo);
    chk(tmo == (busy == 255), "R9", "timeout flag", tmo, busy == 255);
    chk(wn - w0 == en, tag, "write byte count", wn - w0, en);
    ok = 1'b1;
    for (int k = 0; k < en && k < wn - w0; k++)
      if (wk[w0 + k] != ek[k] || wb[w0 + k] != eb[k]) ok = 1'b0;
    chk(ok, tag, "command/address bytes and latch lines", wb[w0], eb[0]);
    chk(rn - r0 == er, (o == 2'd0) ? "R4" : "R8", "read byte count", rn - r0, er);
    ok = 1'b1;
    for (int k = 0; k < er && k < rn - r0; k++)
      if (rv[r0 + k] != ((o == 2'd1) ? id_byte(k) : page_byte(k, p))) ok = 1'b0;
    if (er > 0)
      chk(ok, "R8", "read data stream", rv[r0], (o == 2'd1) ? id_byte(0) : page_byte(0, p));
    if (busy != 255)
      chk(rbusy == b0, "R13", "read started while busy", rbusy - b0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w0, c0, d0;
    repeat (3) @(negedge clk);
    chk({ce, we_n, re_n, cle, ale, dq_oe, done, timeout, rd_valid} == 12'b0000_1100_0000,
        "R1", "outputs in reset",
        {ce, we_n, re_n, cle, ale, dq_oe, done, timeout, rd_valid}, 12'b0000_1100_0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ce, we_n, re_n, cle, ale, dq_oe, done, timeout, rd_valid} == 12'b0000_1100_0000,
        "R1", "outputs after reset",
        {ce, we_n, re_n, cle, ale, dq_oe, done, timeout, rd_valid}, 12'b0000_1100_0000);

    for (int v = 0; v < 7; v++)
      run_op(VEC[v][35:34], VEC[v][33:32], VEC[v][31:8], int'(VEC[v][7:0]), -1);

    // R3: op 3 does nothing
    w0 = wn; c0 = ce_on; d0 = done_seen;
    @(negedge clk); op = 2'd3; chip = 2'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    chk(wn == w0, "R3", "bus writes after op 3", wn - w0, 0);
    chk(ce_on == c0, "R3", "chip select after op 3", ce_on - c0, 0);
    chk(done_seen == d0, "R3", "done after op 3", done_seen - d0, 0);

    // R12: start pulse during a page read is ignored
    run_op(2'd2, 2'd2, 24'h00A5C3, 0, 40);

    chk(bad_we == 0, "R7", "write strobe width errors", bad_we, 0);
    chk(bad_re == 0, "R8", "read strobe width errors", bad_re, 0);
    chk(bad_ce == 0, "R2", "wrong chip selected", bad_ce, 0);
    chk(bad_ce == 0, "R12", "select changed by late start", bad_ce, 0);
    chk(bad_done == 0, "R11", "done longer than one clock", bad_done, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule